// File: doc/BRIEF.md
# Physical Memory Protection Register File with Entry Locking

This block holds a set of protection entries. Each entry has a one-byte configuration and an address register. The block answers permission queries for a physical address. Software-side writes reach the entries through a packed configuration write port and an address write port. Write gating enforces a per-entry lock, and only a hart reset releases a lock. Both register sets can be read back.

A query gives a byte address, a privilege level and an access type. The block returns the read/write/execute permission set for that privilege level and a single allow flag for the requested access. The query path is purely combinational. The lowest-numbered matching entry decides the result. Supervisor and user code get nothing unless an entry grants it. Machine mode is restricted only by locked entries.

Top module: `prot_regs`

## Requirements
- R1: The configuration byte has this layout: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 match mode (0 off, 1 top-of-range, 2 four-byte aligned, 3 power-of-two aligned), bit 7 lock. Bits 6:5 always read as zero.
- R2: Configuration register k packs entries 4k to 4k+3, with entry 4k+j in byte j. A write updates only the bytes of unlocked entries and leaves the other bytes unchanged.
- R3: While an entry's lock bit is set, writes to its configuration byte and to its address register have no effect.
- R4: A set lock bit cannot be cleared by any write. Hart reset (rst_ni low) clears every configuration byte, which sets every mode to off and every lock to 0. Reset also clears every address register.
- R5: If entry i is locked and its mode is top-of-range, writes to the address register of entry i-1 are ignored. Other entries' address registers stay writable.
- R6: The address register holds bits ADDR_W+1:2 of a byte address. In four-byte mode, an entry matches when the query's word address equals the register.
- R7: In power-of-two mode, t trailing ones in the address register select a region of 2^(t+3) bytes. The remaining upper bits give the region base.
- R8: Top-of-range entry i matches word addresses at or above entry i-1's register and strictly below its own register. Entry 0 uses zero as its lower bound.
- R9: When several entries match, the lowest-numbered entry alone decides the permissions.
- R10: Supervisor (priv 1) and user (priv 0) queries get permission only from a matching entry's read, write and execute bits. With no match, they get no permission.
- R11: Machine-mode queries (priv 3) get full permission when nothing matches or when the deciding entry is unlocked. When the deciding entry is locked, its read, write and execute bits apply.
- R12: chk_perm_o gives {execute, write, read} in the same cycle as the query. chk_ok_o is the bit selected by chk_type_i (0 read, 1 write, 2 execute). Type 3 is always denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous hart reset |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_widx_i | input | CFG_IDX_W | Configuration register write index |
| cfg_wdata_i | input | 32 | Packed configuration write data, four bytes |
| addr_we_i | input | 1 | Address register write strobe |
| addr_widx_i | input | IDX_W | Address register write index |
| addr_wdata_i | input | ADDR_W | Address register write data (word address) |
| cfg_ridx_i | input | CFG_IDX_W | Configuration register read index |
| cfg_rdata_o | output | 32 | Configuration register read data |
| addr_ridx_i | input | IDX_W | Address register read index |
| addr_rdata_o | output | ADDR_W | Address register read data |
| chk_addr_i | input | ADDR_W+2 | Query byte address |
| chk_priv_i | input | 2 | Query privilege: 0 user, 1 supervisor, 3 machine |
| chk_type_i | input | 2 | Query access type: 0 read, 1 write, 2 execute |
| chk_perm_o | output | 3 | Granted {execute, write, read} |
| chk_ok_o | output | 1 | Requested access allowed |

## Verification
The bench targets the following failure modes:
- **Locking.** It tries to overwrite a locked entry, to clear its lock by writing, and to change the address register below a locked top-of-range entry. A design that gated on the wrong entry, or that let a lock clear, would show a changed read-back value. The neighbouring unlocked bytes of the same packed register must still update.
- **Region edges.** It probes each mode at its exact edges: the last byte inside and the first byte outside a power-of-two region, both ends of a top-of-range span, and entry 0's zero lower bound. An off-by-one compare or a wrong mask width flips one of those answers.
- **Priority.** Overlapping entries check that the lowest index wins.
- **Machine mode.** Queries against locked and unlocked entries show whether machine mode is wrongly restricted or wrongly left free.

// File: rtl/prot_pkg.sv
package prot_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_NA4   = 2'd2,
    MODE_NAPOT = 2'd3
  } match_mode_e;

  typedef struct packed {
    logic        lock;
    logic [1:0]  rsvd;
    match_mode_e mode;
    logic        x;
    logic        w;
    logic        r;
  } cfg_byte_t;

  localparam logic [1:0] PRIV_M = 2'd3;
  localparam logic [1:0] ACC_R  = 2'd0;
  localparam logic [1:0] ACC_W  = 2'd1;
  localparam logic [1:0] ACC_X  = 2'd2;
  localparam logic [7:0] CFG_WMASK = 8'h9F;

endpackage

// File: rtl/prot_entry.sv
module prot_entry
  import prot_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_wdata_i,
  input  logic              addr_we_i,
  input  logic [ADDR_W-1:0] addr_wdata_i,
  input  logic              upper_tor_lock_i,
  output cfg_byte_t         cfg_o,
  output logic [ADDR_W-1:0] addr_o
);

  cfg_byte_t         cfg_q;
  logic [ADDR_W-1:0] addr_q;
  logic              cfg_wen, addr_wen;

  assign cfg_wen  = cfg_we_i && !cfg_q.lock;
  assign addr_wen = addr_we_i && !cfg_q.lock && !upper_tor_lock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      addr_q <= '0;
    end else begin
      if (cfg_wen)  cfg_q  <= cfg_byte_t'(cfg_wdata_i & CFG_WMASK);
      if (addr_wen) addr_q <= addr_wdata_i;
    end
  end

  assign cfg_o  = cfg_q;
  assign addr_o = addr_q;

endmodule

// File: rtl/prot_match.sv
module prot_match
  import prot_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  match_mode_e       mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] lo_addr_i,
  input  logic [ADDR_W-1:0] qword_i,
  output logic              hit_o
);

  logic [ADDR_W-1:0] napot_mask;

  // trailing ones plus the next bit form the don't-care field
  assign napot_mask = addr_i ^ (addr_i + 1'b1);

  always_comb begin
    unique case (mode_i)
      MODE_TOR:   hit_o = (qword_i >= lo_addr_i) && (qword_i < addr_i);
      MODE_NA4:   hit_o = (qword_i == addr_i);
      MODE_NAPOT: hit_o = ((qword_i ^ addr_i) & ~napot_mask) == '0;
      default:    hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/prot_regs.sv
module prot_regs
  import prot_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned ADDR_W    = 32,
  localparam int unsigned PA_W      = ADDR_W + 2,
  localparam int unsigned N_CFG     = N_ENTRIES / 4,
  localparam int unsigned CFG_IDX_W = (N_CFG > 1) ? $clog2(N_CFG) : 1,
  localparam int unsigned IDX_W     = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [CFG_IDX_W-1:0] cfg_widx_i,
  input  logic [31:0]          cfg_wdata_i,
  input  logic                 addr_we_i,
  input  logic [IDX_W-1:0]     addr_widx_i,
  input  logic [ADDR_W-1:0]    addr_wdata_i,
  input  logic [CFG_IDX_W-1:0] cfg_ridx_i,
  output logic [31:0]          cfg_rdata_o,
  input  logic [IDX_W-1:0]     addr_ridx_i,
  output logic [ADDR_W-1:0]    addr_rdata_o,
  input  logic [PA_W-1:0]      chk_addr_i,
  input  logic [1:0]           chk_priv_i,
  input  logic [1:0]           chk_type_i,
  output logic [2:0]           chk_perm_o,
  output logic                 chk_ok_o
);

  cfg_byte_t                    cfg_arr  [N_ENTRIES];
  logic [ADDR_W-1:0]            addr_arr [N_ENTRIES];
  logic [8*N_ENTRIES-1:0]       cfg_flat;
  logic [ADDR_W*N_ENTRIES-1:0]  addr_flat;
  logic [N_ENTRIES-1:0]         hit;
  logic [ADDR_W-1:0]            qword;
  logic                         unused_lsb;

  assign qword      = chk_addr_i[PA_W-1:2];
  assign unused_lsb = ^chk_addr_i[1:0];

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
    logic              upper_lock;
    logic [ADDR_W-1:0] lo_addr;

    if (i < N_ENTRIES - 1) begin : g_up
      assign upper_lock = cfg_arr[i+1].lock && (cfg_arr[i+1].mode == MODE_TOR);
    end else begin : g_top
      assign upper_lock = 1'b0;
    end

    if (i == 0) begin : g_lo0
      assign lo_addr = '0;
    end else begin : g_lon
      assign lo_addr = addr_arr[i-1];
    end

    prot_entry #(.ADDR_W(ADDR_W)) u_entry (
      .clk_i            (clk_i),
      .rst_ni           (rst_ni),
      .cfg_we_i         (cfg_we_i && (cfg_widx_i == CFG_IDX_W'(i / 4))),
      .cfg_wdata_i      (cfg_wdata_i[8*(i%4) +: 8]),
      .addr_we_i        (addr_we_i && (addr_widx_i == IDX_W'(i))),
      .addr_wdata_i     (addr_wdata_i),
      .upper_tor_lock_i (upper_lock),
      .cfg_o            (cfg_arr[i]),
      .addr_o           (addr_arr[i])
    );

    prot_match #(.ADDR_W(ADDR_W)) u_match (
      .mode_i    (cfg_arr[i].mode),
      .addr_i    (addr_arr[i]),
      .lo_addr_i (lo_addr),
      .qword_i   (qword),
      .hit_o     (hit[i])
    );

    assign cfg_flat[8*i +: 8]          = cfg_arr[i];
    assign addr_flat[ADDR_W*i +: ADDR_W] = addr_arr[i];
  end

  assign cfg_rdata_o  = cfg_flat[32*cfg_ridx_i +: 32];
  assign addr_rdata_o = addr_flat[ADDR_W*addr_ridx_i +: ADDR_W];

  logic       sel_lock;
  logic [2:0] sel_rwx;

  // descending scan so the lowest index is written last
  always_comb begin
    sel_lock = 1'b0;
    sel_rwx  = 3'b000;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (hit[i]) begin
        sel_lock = cfg_arr[i].lock;
        sel_rwx  = {cfg_arr[i].x, cfg_arr[i].w, cfg_arr[i].r};
      end
    end
  end

  always_comb begin
    if (!(|hit))
      chk_perm_o = (chk_priv_i == PRIV_M) ? 3'b111 : 3'b000;
    else if ((chk_priv_i == PRIV_M) && !sel_lock)
      chk_perm_o = 3'b111;
    else
      chk_perm_o = sel_rwx;
  end

  always_comb begin
    unique case (chk_type_i)
      ACC_R:   chk_ok_o = chk_perm_o[0];
      ACC_W:   chk_ok_o = chk_perm_o[1];
      ACC_X:   chk_ok_o = chk_perm_o[2];
      default: chk_ok_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/prot_regs_chk.sv
module prot_regs_chk
  import prot_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned ADDR_W    = 32
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [8*N_ENTRIES-1:0]      cfg_flat_i,
  input logic [ADDR_W*N_ENTRIES-1:0] addr_flat_i,
  input logic [1:0]                  chk_priv_i,
  input logic [1:0]                  chk_type_i,
  input logic [2:0]                  perm_i,
  input logic                        ok_i
);

  logic [N_ENTRIES-1:0] locks;

  always_comb begin
    for (int i = 0; i < N_ENTRIES; i++) locks[i] = cfg_flat_i[8*i+7];
  end

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_chk
    // R1
    rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_flat_i[8*g+5 +: 2] == 2'b00);

    // R4
    lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_flat_i[8*g+7] |=> cfg_flat_i[8*g+7]);

    // R3
    cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_flat_i[8*g+7] |=> $stable(cfg_flat_i[8*g +: 8]));

    // R3
    addr_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_flat_i[8*g+7] |=> $stable(addr_flat_i[ADDR_W*g +: ADDR_W]));

    if (g > 0) begin : g_tor
      // R5
      tor_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_flat_i[8*g+7] && cfg_flat_i[8*g+3 +: 2] == 2'd1)
        |=> $stable(addr_flat_i[ADDR_W*(g-1) +: ADDR_W]));
    end
  end

  // R11
  m_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_priv_i == PRIV_M && locks == '0) |-> perm_i == 3'b111);

  // R12
  ok_perm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_i |-> ((chk_type_i == ACC_R && perm_i[0]) ||
              (chk_type_i == ACC_W && perm_i[1]) ||
              (chk_type_i == ACC_X && perm_i[2])));

endmodule

bind prot_regs prot_regs_chk #(.N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_flat_i  (cfg_flat),
  .addr_flat_i (addr_flat),
  .chk_priv_i  (chk_priv_i),
  .chk_type_i  (chk_type_i),
  .perm_i      (chk_perm_o),
  .ok_i        (chk_ok_o)
);

// File: tb/prot_regs_tb.sv
module prot_regs_tb;

  localparam int N  = 8;
  localparam int AW = 32;
  localparam int PW = AW + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [0:0]    cfg_widx = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          addr_we = 1'b0;
  logic [2:0]    addr_widx = '0;
  logic [AW-1:0] addr_wdata = '0;
  logic [0:0]    cfg_ridx = '0;
  logic [31:0]   cfg_rdata;
  logic [2:0]    addr_ridx = '0;
  logic [AW-1:0] addr_rdata;
  logic [PW-1:0] q_addr = '0;
  logic [1:0]    q_priv = '0;
  logic [1:0]    q_type = '0;
  logic [2:0]    q_perm;
  logic          q_ok;

  int errors = 0;
  int checks = 0;

  localparam logic [1:0] U = 2'd0, S = 2'd1, M = 2'd3;
  localparam logic [1:0] RD = 2'd0, WR = 2'd1, EX = 2'd2;

  always #5 clk = ~clk;

  prot_regs #(.N_ENTRIES(N), .ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_widx_i(cfg_widx), .cfg_wdata_i(cfg_wdata),
    .addr_we_i(addr_we), .addr_widx_i(addr_widx), .addr_wdata_i(addr_wdata),
    .cfg_ridx_i(cfg_ridx), .cfg_rdata_o(cfg_rdata),
    .addr_ridx_i(addr_ridx), .addr_rdata_o(addr_rdata),
    .chk_addr_i(q_addr), .chk_priv_i(q_priv), .chk_type_i(q_type),
    .chk_perm_o(q_perm), .chk_ok_o(q_ok)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wcfg(logic [0:0] idx, logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_widx = idx; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic waddr(logic [2:0] idx, logic [AW-1:0] d);
    @(negedge clk); addr_we = 1'b1; addr_widx = idx; addr_wdata = d;
    @(negedge clk); addr_we = 1'b0;
  endtask

  task automatic rcfg(logic [0:0] idx, logic [31:0] exp, string tag);
    cfg_ridx = idx; #1; check(tag, cfg_rdata, exp);
  endtask

  task automatic raddr(logic [2:0] idx, logic [AW-1:0] exp, string tag);
    addr_ridx = idx; #1; check(tag, addr_rdata, exp);
  endtask

  task automatic q(logic [PW-1:0] a, logic [1:0] p, logic [1:0] t, logic exp, string tag);
    q_addr = a; q_priv = p; q_type = t; #1;
    check(tag, {31'd0, q_ok}, {31'd0, exp});
  endtask

  task automatic t_reset();
    do_reset();
    rcfg(0, 32'h0, "R4 cfg0 reset");
    rcfg(1, 32'h0, "R4 cfg1 reset");
    for (int i = 0; i < N; i++) raddr(3'(i), '0, "R4 addr reset");
    q(34'h0, U, RD, 1'b0, "R10 user no match");
    q(34'h1234, M, WR, 1'b1, "R11 machine no match");
  endtask

  task automatic t_layout();
    wcfg(0, 32'h150C_607F);
    rcfg(0, 32'h150C_001F, "R1 R2 reserved bits zero");
    waddr(5, 32'hDEAD_BEEF);
    raddr(5, 32'hDEAD_BEEF, "R6 addr write");
    do_reset();
  endtask

  task automatic t_na4();
    waddr(0, 32'h100);
    wcfg(0, 32'h0000_0011);
    q(34'h400, U, RD, 1'b1, "R6 na4 hit");
    q(34'h403, U, RD, 1'b1, "R6 na4 last byte");
    q(34'h404, U, RD, 1'b0, "R6 na4 miss");
    q(34'h400, U, WR, 1'b0, "R10 no write bit");
    q(34'h400, S, RD, 1'b1, "R10 supervisor read");
    q(34'h400, M, WR, 1'b1, "R11 unlocked not binding");
  endtask

  task automatic t_napot();
    waddr(1, 32'h807);
    wcfg(0, 32'h0000_1F11);
    q(34'h2000, U, WR, 1'b1, "R7 napot base");
    q(34'h203F, U, WR, 1'b1, "R7 napot top");
    q(34'h2040, U, WR, 1'b0, "R7 napot above");
    q(34'h1FFF, U, WR, 1'b0, "R7 napot below");
  endtask

  task automatic t_tor();
    waddr(2, 32'h400);
    waddr(3, 32'h800);
    wcfg(0, 32'h0C00_1F11);
    q(34'h1000, U, EX, 1'b1, "R8 tor low edge");
    q(34'h1FFC, U, EX, 1'b1, "R8 tor high edge");
    q(34'h0FFC, U, EX, 1'b0, "R8 tor below");
    q(34'h1800, U, RD, 1'b0, "R8 tor exec only");
    q(34'h1000, U, 2'd3, 1'b0, "R12 type 3 denied");
    check("R12 perm vector", {29'd0, q_perm}, 32'h4);
  endtask

  task automatic t_prio();
    waddr(4, 32'h0FF);
    wcfg(1, 32'h0000_001F);
    q(34'h400, U, WR, 1'b0, "R9 lower entry wins");
    q(34'h408, U, WR, 1'b1, "R9 fallthrough to entry 4");
    q(34'h400, U, RD, 1'b1, "R9 lower entry read");
  endtask

  task automatic t_tor0();
    do_reset();
    waddr(0, 32'h40);
    wcfg(0, 32'h0000_000B);
    q(34'h0, U, RD, 1'b1, "R8 entry0 zero bound");
    q(34'hFC, U, WR, 1'b1, "R8 entry0 top");
    q(34'h100, U, RD, 1'b0, "R8 entry0 end exclusive");
  endtask

  task automatic t_lock();
    do_reset();
    waddr(0, 32'h100);
    wcfg(0, 32'h0000_0091);
    wcfg(0, 32'h0000_1F1F);
    rcfg(0, 32'h0000_1F91, "R2 R3 locked byte kept");
    waddr(0, 32'h200);
    raddr(0, 32'h100, "R3 locked addr kept");
    wcfg(0, 32'h0000_1F00);
    rcfg(0, 32'h0000_1F91, "R4 lock not clearable");
    q(34'h400, M, WR, 1'b0, "R11 locked binds machine");
    q(34'h400, M, RD, 1'b1, "R11 locked read granted");
    q(34'h404, M, WR, 1'b1, "R11 machine outside");
  endtask

  task automatic t_tor_lock();
    do_reset();
    waddr(4, 32'h10);
    waddr(5, 32'h20);
    wcfg(1, 32'h0000_8900);
    waddr(4, 32'h99);
    raddr(4, 32'h10, "R5 below tor lock kept");
    waddr(5, 32'h99);
    raddr(5, 32'h20, "R3 tor own addr kept");
    waddr(6, 32'h77);
    raddr(6, 32'h77, "R5 above unaffected");
    waddr(3, 32'h55);
    raddr(3, 32'h55, "R5 two below unaffected");
    wcfg(1, 32'h0000_0011);
    rcfg(1, 32'h0000_8911, "R2 partial byte update");
    do_reset();
    rcfg(1, 32'h0, "R4 reset clears lock");
    raddr(5, 32'h0, "R4 reset clears addr");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_layout();
    t_na4();
    t_napot();
    t_tor();
    t_prio();
    t_tor0();
    t_lock();
    t_tor_lock();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule